// File: doc/BRIEF.md
# ALU Output Shifter with Bypass

This block is the last stage of an 8-bit ALU datapath. It picks what reaches the write-back bus: the ALU result as is, the ALU result moved right by one place, or the data bus routed around the ALU. Every path is combinational, so the chosen value appears in the same cycle as its inputs.

No dedicated control bit enables the right shift. The microcode puts an otherwise unused code, binary 0001, on the 4-bit ALU input-select field. This block recognises that code, turns the shift on, and hands the ALU the code 0000 in its place. A separate microcode bit picks between a rotate, where the top bit comes from the carry flag, and a logical shift, where the top bit is zero. During a shift the bit that drops off the bottom becomes the new carry. Outside a shift the carry passes through unchanged.

Top module: `aluOutStage`

## Requirements
- R1: When bypass is low and the select code is not 0001, `wbOut` equals `aluResult` and `carryOut` equals `carryIn`.
- R2: A select code of 0001 on `aluSelIn` leaves the block as 0000 on `aluSelOut`, whatever the bypass and rotate inputs are.
- R3: Every select code other than 0001 is passed to `aluSelOut` unchanged.
- R4: When bypass is low and the select code is 0001, bit i of `wbOut` equals bit i+1 of `aluResult` for i from 0 to 6.
- R5: During a shift with `rotateSel` = 1, bit 7 of `wbOut` equals `carryIn`.
- R6: During a shift with `rotateSel` = 0, bit 7 of `wbOut` is 0.
- R7: During a shift, `carryOut` equals bit 0 of `aluResult`.
- R8: When `bypassEn` is 1, `wbOut` equals `dataBus` and `carryOut` equals `carryIn`, even when the select code is 0001 (bypass wins over the shift).
- R9: When no shift is taking place, `rotateSel` has no effect on `wbOut` or `carryOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aluResult | input | 8 | Result from the arithmetic core |
| dataBus | input | 8 | Internal data bus value for the bypass path |
| carryIn | input | 1 | Current carry flag |
| aluSelIn | input | 4 | ALU input-select code from microcode (0001 means shift right) |
| rotateSel | input | 1 | 1 = rotate through carry, 0 = logical shift |
| bypassEn | input | 1 | 1 = put the data bus on the write-back bus |
| wbOut | output | 8 | Write-back bus value |
| carryOut | output | 1 | New carry value |
| aluSelOut | output | 4 | Select code sent on to the ALU |

## Verification
The bench applies every combination of select code, ALU result, carry, rotate and bypass. This covers the corner cases where a wrong design shows itself:
- Select code 0001 with bypass high: a design with the wrong priority would put a shifted value on the bus.
- A rotate with carry set: a design that wires the top bit wrongly would drop or duplicate the carry.
- Results whose bit 0 differs from the carry: a design that never updates the carry on a shift, or updates it outside one, is exposed here.
- Codes next to 0001, such as 0000, 0011 and 1001: a loose decode would rewrite them or start a shift by mistake.

// File: rtl/aluOutPkg.sv
package aluOutPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // shift right selected
    logic rotateEn;  // top bit from carry
    logic bypassEn;  // route data bus to write-back
  } outStrobesT;
endpackage

// File: rtl/aluOutCtrl.sv
module aluOutCtrl
  import aluOutPkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int SHIFT_CODE = 1
) (
  input  logic [SEL_W-1:0] selIn,
  input  logic             rotateReq,
  input  logic             bypassReq,
  output outStrobesT       strobes,
  output logic [SEL_W-1:0] selOut
);
  localparam logic [SEL_W-1:0] ShiftCode = SEL_W'(SHIFT_CODE);

  logic isShiftCode;

  always_comb begin
    isShiftCode      = (selIn == ShiftCode);
    // The borrowed code must never reach the ALU
    selOut           = isShiftCode ? '0 : selIn;
    strobes.bypassEn = bypassReq;
    // Bypass outranks the shift
    strobes.shiftEn  = isShiftCode && !bypassReq;
    strobes.rotateEn = rotateReq;
  end
endmodule

// File: rtl/aluOutPath.sv
module aluOutPath
  import aluOutPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              carryIn,
  input  outStrobesT        strobes,
  output logic [DATA_W-1:0] wbOut,
  output logic              carryOut
);
  localparam int TopBit = DATA_W - 1;

  logic [DATA_W-1:0] shifted;
  logic              fillBit;

  assign fillBit = strobes.rotateEn & carryIn;

  // Each lower bit takes its upper neighbour
  for (genvar i = 0; i < TopBit; i++) begin : gShift
    assign shifted[i] = aluResult[i+1];
  end
  assign shifted[TopBit] = fillBit;

  always_comb begin
    if (strobes.bypassEn) begin
      wbOut    = dataBus;
      carryOut = carryIn;
    end else if (strobes.shiftEn) begin
      wbOut    = shifted;
      carryOut = aluResult[0];
    end else begin
      wbOut    = aluResult;
      carryOut = carryIn;
    end
  end
endmodule

// File: rtl/aluOutStage.sv
module aluOutStage
  import aluOutPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 4,
  parameter int SHIFT_CODE = 1
) (
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              carryIn,
  input  logic [SEL_W-1:0]  aluSelIn,
  input  logic              rotateSel,
  input  logic              bypassEn,
  output logic [DATA_W-1:0] wbOut,
  output logic              carryOut,
  output logic [SEL_W-1:0]  aluSelOut
);
  outStrobesT strobes;

  aluOutCtrl #(.SEL_W(SEL_W), .SHIFT_CODE(SHIFT_CODE)) ctrl (
    .selIn(aluSelIn), .rotateReq(rotateSel), .bypassReq(bypassEn),
    .strobes(strobes), .selOut(aluSelOut)
  );

  aluOutPath #(.DATA_W(DATA_W)) path (
    .aluResult(aluResult), .dataBus(dataBus), .carryIn(carryIn),
    .strobes(strobes), .wbOut(wbOut), .carryOut(carryOut)
  );
endmodule

// File: rtl/aluOutChk.sv
module aluOutChk #(
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 4,
  parameter int SHIFT_CODE = 1
) (
  input logic [DATA_W-1:0] aluResult,
  input logic [DATA_W-1:0] dataBus,
  input logic              carryIn,
  input logic [SEL_W-1:0]  aluSelIn,
  input logic              rotateSel,
  input logic              bypassEn,
  input logic [DATA_W-1:0] wbOut,
  input logic              carryOut,
  input logic [SEL_W-1:0]  aluSelOut
);
  localparam logic [SEL_W-1:0] ShiftCode = SEL_W'(SHIFT_CODE);

  always_comb begin
    if (aluSelIn == ShiftCode)
      AST_SEL_REWRITE: assert (aluSelOut == '0) else $error("sel rewrite"); // R2
    else
      AST_SEL_FORWARD: assert (aluSelOut == aluSelIn) else $error("sel fwd"); // R3
    if (bypassEn)
      AST_BYPASS_WINS: assert (wbOut == dataBus && carryOut == carryIn) else $error("bypass"); // R8
    else if (aluSelIn == ShiftCode) begin
      AST_SHIFT_BODY: assert (wbOut[DATA_W-2:0] == aluResult[DATA_W-1:1]) else $error("shift"); // R4
      AST_SHIFT_TOP: assert (wbOut[DATA_W-1] == (rotateSel & carryIn)) else $error("top"); // R5
      AST_SHIFT_CARRY: assert (carryOut == aluResult[0]) else $error("carry"); // R7
    end else
      AST_PASS_THRU: assert (wbOut == aluResult && carryOut == carryIn) else $error("pass"); // R1
  end
endmodule

bind aluOutStage aluOutChk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SHIFT_CODE(SHIFT_CODE)) chk (.*);

// File: tb/aluOutStage_test.sv
module aluOutStage_test;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [7:0] aluResult, dataBus, wbOut;
  logic       carryIn, rotateSel, bypassEn, carryOut;
  logic [3:0] aluSelIn, aluSelOut;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  aluOutStage uut (.*);

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : stim
    aluResult = 0; dataBus = 0; carryIn = 0;
    aluSelIn = 0; rotateSel = 0; bypassEn = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // Idle state after reset: all-zero inputs give all-zero outputs (R1, R3)
    chk8("R1 idle wb", wbOut, 8'h00);
    chk8("R3 idle sel", {4'h0, aluSelOut}, 8'h00);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 16; s++)
            for (int a = 0; a < 256; a++) begin
              logic [7:0] expWb;
              logic       expC;
              string      tag;
              @(posedge clk);
              aluResult = 8'(a);
              dataBus   = 8'(a) ^ 8'h5A ^ 8'(s * 17);
              carryIn   = c[0];
              rotateSel = r[0];
              bypassEn  = b[0];
              aluSelIn  = 4'(s);
              @(negedge clk);
              if (b == 1) begin
                expWb = dataBus; expC = c[0]; tag = "R8";
              end else if (s == 1) begin
                expWb = 8'(a / 2) + (r == 1 ? 8'(c * 128) : 8'h00);
                expC  = a[0];
                tag   = (r == 1) ? "R4/R5 rotate" : "R4/R6 logical";
              end else begin
                expWb = 8'(a); expC = c[0];
                tag   = (r == 1) ? "R1/R9" : "R1";
              end
              chk8({tag, " wb"}, wbOut, expWb);
              chk8((s == 1 && b == 0) ? "R7 carry" : {tag, " carry"},
                   {7'd0, carryOut}, {7'd0, expC});
              chk8((s == 1) ? "R2 sel" : "R3 sel",
                   {4'h0, aluSelOut}, (s == 1) ? 8'h00 : 8'(s));
            end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule